// File: doc/BRIEF.md
# Two-Line Collapsing Fetch Aligner

This block sits between a two-bank instruction cache and the decode stage. Each cycle it receives two cache lines, one from each bank, with a per-slot valid mask that the branch predictor has already formed. Slots that follow a predicted-taken branch, or lie before the fetch entry point, arrive marked invalid.

A single flag tells the block which bank holds the line that comes first in program order. An interchange stage puts the two lines in that order. A compaction network then closes up every gap left by invalid slots. Decode therefore receives one dense group whose length can run past a taken branch that falls inside a line.

The group and its length are registered, so the result appears one cycle after the inputs are presented. Both the cache lookup and the branch target lookup lie outside this block.

Top module: `fetch_collapse`

## Requirements
- R1: While reset is asserted (rst_n low), grp_count is 0 and every bit of grp_instr is 0.
- R2: first_is_bank1 = 0 places bank 0's line first in program order, and first_is_bank1 = 1 places bank 1's line first. Within a line, slot k occupies bits [k*32 +: 32] of the line input, and slot 0 is the earliest.
- R3: Output slot j (bits [j*32 +: 32] of grp_instr) holds the j-th valid instruction in program order, counting from 0. Valid instructions keep their relative order.
- R4: grp_count equals the number of set bits across bank0_mask and bank1_mask.
- R5: Every output slot j with j >= grp_count is all zeros.
- R6: The outputs change only at a rising clock edge. They reflect the inputs sampled at the previous edge, which gives one cycle of latency.
- R7: Consider a first line A B C D and a second line E F G H in which D, F and H are invalid. The group is then A B C E G and the count is 5.
- R8: Mask bit k qualifies slot k of the same bank. The contents of an invalid slot have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank0_line | input | 128 | Four 32-bit instructions from bank 0, slot 0 in the low bits |
| bank0_mask | input | 4 | Valid bits for bank 0's slots |
| bank1_line | input | 128 | Four 32-bit instructions from bank 1, slot 0 in the low bits |
| bank1_mask | input | 4 | Valid bits for bank 1's slots |
| first_is_bank1 | input | 1 | 1 when bank 1 holds the earlier line |
| grp_instr | output | 256 | Compacted group, output slot 0 in the low bits |
| grp_count | output | 4 | Number of valid instructions in the group |

## Verification
Some properties are checked on every cycle. These are the reset clearing, the count against the population of the previous cycle's masks, the zero tail beyond the count, the head slot under either line order, and full passthrough when every slot is valid. Other behaviours can only be shown by the bench's scenarios. These are the exact position of every middle instruction under all 256 mask patterns in both orders, the insensitivity to the data held in invalid slots, the worked five-instruction example, and the fact that the outputs hold between edges.

// File: rtl/fetch_collapse_pkg.sv
package fetch_collapse_pkg;
  typedef enum logic {
    ORDER_BANK0_FIRST = 1'b0,
    ORDER_BANK1_FIRST = 1'b1
  } line_order_e;
endpackage

// File: rtl/fetch_collapse_swap.sv
module fetch_collapse_swap
  import fetch_collapse_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int W     = 32
) (
  input  logic [SLOTS*W-1:0]   b0_data,
  input  logic [SLOTS-1:0]     b0_vld,
  input  logic [SLOTS*W-1:0]   b1_data,
  input  logic [SLOTS-1:0]     b1_vld,
  input  line_order_e          order,
  output logic [2*SLOTS*W-1:0] seq_data,
  output logic [2*SLOTS-1:0]   seq_vld
);
  // Low half of the sequence is the earlier line.
  always_comb begin
    if (order == ORDER_BANK1_FIRST) begin
      seq_data = {b0_data, b1_data};
      seq_vld  = {b0_vld, b1_vld};
    end else begin
      seq_data = {b1_data, b0_data};
      seq_vld  = {b1_vld, b0_vld};
    end
  end
endmodule

// File: rtl/fetch_collapse_net.sv
module fetch_collapse_net #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N*W-1:0]   seq_data,
  input  logic [N-1:0]     seq_vld,
  output logic [N*W-1:0]   cmp_data,
  output logic [CNT_W-1:0] cmp_cnt
);
  // rank[i]: number of valid slots strictly before slot i
  logic [CNT_W-1:0] rank [N+1];

  always_comb begin
    rank[0] = '0;
    for (int i = 0; i < N; i++) begin
      rank[i+1] = rank[i] + CNT_W'(seq_vld[i]);
    end
  end

  assign cmp_cnt = rank[N];

  // Output slot j takes the valid input whose rank is j (at most one matches).
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int i = j; i < N; i++) begin
        if (seq_vld[i] && (rank[i] == CNT_W'(j))) begin
          pick = pick | seq_data[i*W +: W];
        end
      end
    end
    assign cmp_data[j*W +: W] = pick;
  end
endmodule

// File: rtl/fetch_collapse_oreg.sv
module fetch_collapse_oreg #(
  parameter int N     = 8,
  parameter int W     = 32,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N*W-1:0]   d_data,
  input  logic [CNT_W-1:0] d_cnt,
  output logic [N*W-1:0]   q_data,
  output logic [CNT_W-1:0] q_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_cnt  <= '0;
    end else begin
      q_data <= d_data;
      q_cnt  <= d_cnt;
    end
  end
endmodule

// File: rtl/fetch_collapse.sv
module fetch_collapse
  import fetch_collapse_pkg::*;
#(
  parameter int INSTR_W    = 32,
  parameter int LINE_SLOTS = 4,
  localparam int GROUP     = 2 * LINE_SLOTS,
  localparam int CNT_W     = $clog2(GROUP + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LINE_SLOTS*INSTR_W-1:0] bank0_line,
  input  logic [LINE_SLOTS-1:0]         bank0_mask,
  input  logic [LINE_SLOTS*INSTR_W-1:0] bank1_line,
  input  logic [LINE_SLOTS-1:0]         bank1_mask,
  input  logic                          first_is_bank1,
  output logic [GROUP*INSTR_W-1:0]      grp_instr,
  output logic [CNT_W-1:0]              grp_count
);
  line_order_e                order;
  logic [GROUP*INSTR_W-1:0]   seq_data;
  logic [GROUP-1:0]           seq_vld;
  logic [GROUP*INSTR_W-1:0]   cmp_data;
  logic [CNT_W-1:0]           cmp_cnt;

  assign order = line_order_e'(first_is_bank1);

  fetch_collapse_swap #(.SLOTS(LINE_SLOTS), .W(INSTR_W)) u_swap (
    .b0_data (bank0_line),
    .b0_vld  (bank0_mask),
    .b1_data (bank1_line),
    .b1_vld  (bank1_mask),
    .order   (order),
    .seq_data(seq_data),
    .seq_vld (seq_vld)
  );

  fetch_collapse_net #(.N(GROUP), .W(INSTR_W), .CNT_W(CNT_W)) u_net (
    .seq_data(seq_data),
    .seq_vld (seq_vld),
    .cmp_data(cmp_data),
    .cmp_cnt (cmp_cnt)
  );

  fetch_collapse_oreg #(.N(GROUP), .W(INSTR_W), .CNT_W(CNT_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_data(cmp_data),
    .d_cnt (cmp_cnt),
    .q_data(grp_instr),
    .q_cnt (grp_count)
  );
endmodule

// File: rtl/fetch_collapse_chk.sv
module fetch_collapse_chk #(
  parameter int INSTR_W    = 32,
  parameter int LINE_SLOTS = 4,
  localparam int GROUP     = 2 * LINE_SLOTS,
  localparam int CNT_W     = $clog2(GROUP + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [LINE_SLOTS*INSTR_W-1:0] bank0_line,
  input logic [LINE_SLOTS-1:0]         bank0_mask,
  input logic [LINE_SLOTS*INSTR_W-1:0] bank1_line,
  input logic [LINE_SLOTS-1:0]         bank1_mask,
  input logic                          first_is_bank1,
  input logic [GROUP*INSTR_W-1:0]      grp_instr,
  input logic [CNT_W-1:0]              grp_count
);
  logic tail_bad;
  always_comb begin
    tail_bad = 1'b0;
    for (int k = 0; k < GROUP; k++) begin
      if ((k >= int'(grp_count)) && (grp_instr[k*INSTR_W +: INSTR_W] != '0)) tail_bad = 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (grp_count == '0 && grp_instr == '0));

  p_count_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(grp_count) == $countones({$past(bank1_mask), $past(bank0_mask)}));

  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tail_bad);

  p_full_b0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank0_mask && &bank1_mask && !first_is_bank1)
      |=> grp_instr == {$past(bank1_line), $past(bank0_line)});

  p_full_b1_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank0_mask && &bank1_mask && first_is_bank1)
      |=> grp_instr == {$past(bank0_line), $past(bank1_line)});

  p_head_b0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_is_bank1 && bank0_mask[0])
      |=> grp_instr[INSTR_W-1:0] == $past(bank0_line[INSTR_W-1:0]));

  p_head_b1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (first_is_bank1 && bank1_mask[0])
      |=> grp_instr[INSTR_W-1:0] == $past(bank1_line[INSTR_W-1:0]));
endmodule

bind fetch_collapse fetch_collapse_chk #(.INSTR_W(INSTR_W), .LINE_SLOTS(LINE_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bank0_line    (bank0_line),
  .bank0_mask    (bank0_mask),
  .bank1_line    (bank1_line),
  .bank1_mask    (bank1_mask),
  .first_is_bank1(first_is_bank1),
  .grp_instr     (grp_instr),
  .grp_count     (grp_count)
);

// File: tb/fetch_collapse_bench.sv
module fetch_collapse_bench;
  localparam int W = 32;
  localparam int S = 4;
  localparam int G = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [S*W-1:0] bank0_line = '0;
  logic [S-1:0]   bank0_mask = '0;
  logic [S*W-1:0] bank1_line = '0;
  logic [S-1:0]   bank1_mask = '0;
  logic           first_is_bank1 = 1'b0;
  logic [G*W-1:0] grp_instr;
  logic [3:0]     grp_count;

  int n_tests = 0;
  int n_fail  = 0;
  logic [G*W-1:0] exp_data, prev_data;
  int             exp_cnt, prev_cnt;

  always #5 clk = ~clk;

  fetch_collapse u_fetch_collapse (.*);

  function automatic logic [W-1:0] tagword(int bank, int slot, int tag);
    return {8'(8'hC0 + bank), 8'(slot), 16'(tag)};
  endfunction

  // Expected group: walk program positions, map each to its bank and slot.
  task automatic model();
    exp_data = '0;
    exp_cnt  = 0;
    for (int p = 0; p < G; p++) begin
      int bank = (p / S) ^ int'(first_is_bank1);
      int s    = p % S;
      logic v  = (bank == 1) ? bank1_mask[s] : bank0_mask[s];
      if (v) begin
        exp_data[exp_cnt*W +: W] = (bank == 1) ? bank1_line[s*W +: W] : bank0_line[s*W +: W];
        exp_cnt++;
      end
    end
  endtask

  task automatic check(string req, logic [G*W-1:0] ed, int ec);
    n_tests++;
    if (grp_instr !== ed || int'(grp_count) != ec) begin
      n_fail++;
      $display("FAIL %s: got count %0d data %h, expected count %0d data %h",
               req, grp_count, grp_instr, ec, ed);
    end
  endtask

  // Drive at a negedge, then check one edge later at the following negedge.
  task automatic run_vec(logic [S-1:0] m0, logic [S-1:0] m1, logic f, int tag, string req);
    for (int s = 0; s < S; s++) begin
      bank0_line[s*W +: W] = tagword(0, s, tag);
      bank1_line[s*W +: W] = tagword(1, s, tag);
    end
    bank0_mask = m0;
    bank1_mask = m1;
    first_is_bank1 = f;
    model();
    @(posedge clk);
    @(negedge clk);
    check(req, exp_data, exp_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, with live inputs applied
    @(negedge clk);
    bank0_mask = 4'hF; bank1_mask = 4'hF;
    bank0_line = {S*W{1'b1}};
    @(posedge clk); @(negedge clk);
    check("R1", '0, 0);
    @(negedge clk);
    check("R1", '0, 0);
    rst_n = 1'b1;

    // R7: worked example; slot 3 of first line, slots 1 and 3 of second invalid
    run_vec(4'b0111, 4'b0101, 1'b0, 7, "R7");
    begin
      logic [G*W-1:0] e7 = '0;
      e7[0*W +: W] = tagword(0, 0, 7);
      e7[1*W +: W] = tagword(0, 1, 7);
      e7[2*W +: W] = tagword(0, 2, 7);
      e7[3*W +: W] = tagword(1, 0, 7);
      e7[4*W +: W] = tagword(1, 2, 7);
      check("R7", e7, 5);
    end
    // R7 with the banks swapped: the same group must come out
    run_vec(4'b0101, 4'b0111, 1'b1, 8, "R7");

    // R2/R3/R4/R5: exhaustive sweep of masks under both orders
    for (int f = 0; f < 2; f++) begin
      for (int m = 0; m < 256; m++) begin
        run_vec(m[3:0], m[7:4], f[0], m + 256 * f, (f == 0) ? "R3_R4_R5_order0_R2" : "R3_R4_R5_order1_R2");
      end
    end

    // R8: rewrite invalid slots with junk, output must stay the same
    for (int m = 0; m < 16; m++) begin
      run_vec(m[3:0], ~m[3:0], m[0], 900 + m, "R8");
      for (int s = 0; s < S; s++) begin
        if (!bank0_mask[s]) bank0_line[s*W +: W] = 32'hDEAD0000 | 32'(s);
        if (!bank1_mask[s]) bank1_line[s*W +: W] = 32'hBEEF0000 | 32'(s);
      end
      @(posedge clk); @(negedge clk);
      check("R8", exp_data, exp_cnt);
    end

    // R6: a new input does not reach the outputs before the next edge
    for (int k = 0; k < 6; k++) begin
      prev_data = grp_instr;
      prev_cnt  = int'(grp_count);
      for (int s = 0; s < S; s++) begin
        bank0_line[s*W +: W] = tagword(0, s, 2000 + k);
        bank1_line[s*W +: W] = tagword(1, s, 2000 + k);
      end
      bank0_mask = 4'(k + 3); bank1_mask = 4'(9 - k); first_is_bank1 = k[0];
      model();
      #2;
      check("R6_hold", prev_data, prev_cnt);
      @(posedge clk); @(negedge clk);
      check("R6_update", exp_data, exp_cnt);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule